// File: doc/BRIEF.md
# Extended interrupt routing core

This block sits between a wide vector of level-sensitive device interrupt lines and a small set of CPUs, each of which has a few interrupt pins. Every line is steered to one target CPU. Every group of 32 lines is steered to one pin number. For each CPU and pin, the block drives a level that is high while that CPU's status word holds at least one line of a group mapped to that pin.

A status bit is an event-driven record. It is set when a line becomes active while enabled, when an enable is raised on an already active line, or when an active, enabled line is moved onto that CPU. It is cleared when the line falls, when its enable drops, when the line moves away, or when the CPU strobes a write-1-to-clear. The raw level of every line is remembered whether or not the line is enabled, so a later enable or route change acts on the true pending state. Register decoding and the storage of routing bytes stay outside. The block receives the enable words, the decoded per-line CPU index, the per-group pin index and the clear strobes as plain vectors.

Top module: `extirq_route`

## Requirements
- R1: After reset every status bit and every pin output is 0, and the captured pin of every group is 0.
- R2: A line that rises while its enable bit is 1 sets bit `c*N_LINES+l` of `status_o`, where `c` is the CPU index held in `core_sel_i[l*CPU_W +: CPU_W]`. A line that rises while its enable is 0 sets no status bit, but its raw level is kept.
- R3: A line that falls clears its status bit.
- R4: An enable bit that goes 0→1 while its line is high sets the status bit at the line's target. An enable bit that goes 1→0 clears that status bit.
- R5: When `core_sel_i` of a high, enabled line changes, its status bit moves from the old CPU to the new one. A line's status bit is never held by more than one CPU.
- R6: The pin is chosen per group `g = l/32` by `pin_sel_i[g*PIN_W +: PIN_W]`. `pin_o[c*N_PIN+p]` is the OR of CPU `c`'s status bits over all groups whose effective pin is `p`.
- R7: A group's pin is captured from `pin_sel_i` only while no CPU holds a status bit of that group. A pin map change made while the group is busy leaves the outputs unchanged until the group next goes idle.
- R8: A 1 on `clr_i[c*N_LINES+l]` clears that status bit and recomputes the pin. The bit is not set again while the line merely stays high; it needs a new event (R2, R4 or R5).
- R9: Every output is registered. A change on any input appears on `status_o` and `pin_o` one clock edge later and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_LINES | Raw level-sensitive interrupt lines |
| en_i | input | N_LINES | Per-line enable |
| core_sel_i | input | N_LINES*CPU_W | Target CPU index per line, field `l*CPU_W` |
| pin_sel_i | input | N_GROUPS*PIN_W | Pin index per 32-line group, field `g*PIN_W` |
| clr_i | input | N_CPU*N_LINES | Write-1-to-clear strobes, bit `c*N_LINES+l` |
| pin_o | output | N_CPU*N_PIN | CPU pin levels, bit `c*N_PIN+p` |
| status_o | output | N_CPU*N_LINES | Per-CPU status words, bit `c*N_LINES+l` |

## Verification
Directed vectors separate the event sources one at a time. A rise while disabled followed by a late enable shows that the raw level is kept. A reroute of a pending line shows that the bit moves rather than being duplicated or lost. A pin map change under load, followed by a clear, shows that capture is deferred until the group is idle. A long sweep then changes one kind of stimulus per step: sparse line toggles, enable flips, reroutes of a few lines, pin map rewrites and clear strobes. Each step is compared against an event model. Mixing the kinds tells apart stale-state bugs, such as a re-set after a clear or a missed move, from plain routing errors.

// File: rtl/extirq_pkg.sv
`timescale 1ns/1ps
package extirq_pkg;
  localparam int GROUP_SIZE = 32;
endpackage

// File: rtl/extirq_line_edge.sv
`timescale 1ns/1ps
module extirq_line_edge #(
  parameter int N_LINES = 64,
  parameter int CPU_W   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_LINES-1:0]         irq_i,
  input  logic [N_LINES-1:0]         en_i,
  input  logic [N_LINES*CPU_W-1:0]   core_i,
  output logic [N_LINES-1:0]         evt_o
);
  logic [N_LINES-1:0]       irq_q, en_q;
  logic [N_LINES*CPU_W-1:0] core_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      en_q   <= '0;
      core_q <= '0;
    end else begin
      irq_q  <= irq_i;
      en_q   <= en_i;
      core_q <= core_i;
    end
  end

  // event: line rose, enable rose, or target moved
  for (genvar l = 0; l < N_LINES; l++) begin : g_evt
    assign evt_o[l] = (irq_i[l] & ~irq_q[l]) | (en_i[l] & ~en_q[l]) |
                      (core_i[l*CPU_W +: CPU_W] != core_q[l*CPU_W +: CPU_W]);
  end
endmodule

// File: rtl/extirq_status_bank.sv
`timescale 1ns/1ps
module extirq_status_bank #(
  parameter int N_LINES = 64,
  parameter int CPU_W   = 2,
  parameter int CPU_ID  = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_LINES-1:0]       irq_i,
  input  logic [N_LINES-1:0]       en_i,
  input  logic [N_LINES*CPU_W-1:0] core_i,
  input  logic [N_LINES-1:0]       evt_i,
  input  logic [N_LINES-1:0]       clr_i,
  output logic [N_LINES-1:0]       st_d_o,
  output logic [N_LINES-1:0]       st_q_o
);
  logic [N_LINES-1:0] tgt;

  always_comb begin
    for (int l = 0; l < N_LINES; l++) begin
      tgt[l] = (core_i[l*CPU_W +: CPU_W] == CPU_W'(CPU_ID));
      if (!tgt[l] || !irq_i[l] || !en_i[l] || clr_i[l]) st_d_o[l] = 1'b0;
      else if (evt_i[l])                                 st_d_o[l] = 1'b1;
      else                                               st_d_o[l] = st_q_o[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q_o <= '0;
    else         st_q_o <= st_d_o;
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_chk
    // R2
    st_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_q_o[l] |-> $past(irq_i[l] && en_i[l] && tgt[l]));
    // R8
    clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(clr_i[l]) |-> !st_q_o[l]);
  end
endmodule

// File: rtl/extirq_pin_merge.sv
`timescale 1ns/1ps
module extirq_pin_merge
  import extirq_pkg::*;
#(
  parameter int N_LINES  = 64,
  parameter int N_CPU    = 4,
  parameter int N_PIN    = 4,
  localparam int PIN_W    = $clog2(N_PIN),
  localparam int N_GROUPS = N_LINES / GROUP_SIZE
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_GROUPS*PIN_W-1:0] pin_sel_i,
  input  logic [N_CPU*N_LINES-1:0]  st_q_i,
  input  logic [N_CPU*N_LINES-1:0]  st_d_i,
  output logic [N_CPU*N_PIN-1:0]    pin_o
);
  logic [N_GROUPS-1:0][PIN_W-1:0] cap_q, eff;
  logic [N_CPU*N_PIN-1:0]         pin_d;

  always_comb begin
    for (int g = 0; g < N_GROUPS; g++) begin
      logic busy;
      busy = 1'b0;
      for (int c = 0; c < N_CPU; c++)
        busy = busy | (|st_q_i[c*N_LINES + g*GROUP_SIZE +: GROUP_SIZE]);
      // hold the captured pin while the group has live status
      eff[g] = busy ? cap_q[g] : pin_sel_i[g*PIN_W +: PIN_W];
    end
    pin_d = '0;
    for (int c = 0; c < N_CPU; c++)
      for (int g = 0; g < N_GROUPS; g++)
        pin_d[c*N_PIN + int'(eff[g])] = pin_d[c*N_PIN + int'(eff[g])] |
            (|st_d_i[c*N_LINES + g*GROUP_SIZE +: GROUP_SIZE]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      pin_o <= '0;
    end else begin
      cap_q <= eff;
      pin_o <= pin_d;
    end
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
      // R6
      pin_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pin_o[c*N_PIN+p] |-> (|st_q_i[c*N_LINES +: N_LINES]));
    end
  end
endmodule

// File: rtl/extirq_route.sv
`timescale 1ns/1ps
module extirq_route
  import extirq_pkg::*;
#(
  parameter int N_LINES  = 64,
  parameter int N_CPU    = 4,
  parameter int N_PIN    = 4,
  localparam int CPU_W    = $clog2(N_CPU),
  localparam int PIN_W    = $clog2(N_PIN),
  localparam int N_GROUPS = N_LINES / GROUP_SIZE
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_LINES-1:0]        irq_i,
  input  logic [N_LINES-1:0]        en_i,
  input  logic [N_LINES*CPU_W-1:0]  core_sel_i,
  input  logic [N_GROUPS*PIN_W-1:0] pin_sel_i,
  input  logic [N_CPU*N_LINES-1:0]  clr_i,
  output logic [N_CPU*N_PIN-1:0]    pin_o,
  output logic [N_CPU*N_LINES-1:0]  status_o
);
  logic [N_LINES-1:0]       evt;
  logic [N_CPU*N_LINES-1:0] st_d;

  extirq_line_edge #(.N_LINES(N_LINES), .CPU_W(CPU_W)) u_edge (
    .clk_i, .rst_ni, .irq_i, .en_i, .core_i(core_sel_i), .evt_o(evt)
  );

  for (genvar c = 0; c < N_CPU; c++) begin : g_bank
    extirq_status_bank #(.N_LINES(N_LINES), .CPU_W(CPU_W), .CPU_ID(c)) u_bank (
      .clk_i, .rst_ni, .irq_i, .en_i, .core_i(core_sel_i), .evt_i(evt),
      .clr_i (clr_i[c*N_LINES +: N_LINES]),
      .st_d_o(st_d[c*N_LINES +: N_LINES]),
      .st_q_o(status_o[c*N_LINES +: N_LINES])
    );
  end

  extirq_pin_merge #(.N_LINES(N_LINES), .N_CPU(N_CPU), .N_PIN(N_PIN)) u_merge (
    .clk_i, .rst_ni, .pin_sel_i, .st_q_i(status_o), .st_d_i(st_d), .pin_o
  );

  for (genvar l = 0; l < N_LINES; l++) begin : g_own
    logic [N_CPU-1:0] owners;
    for (genvar c = 0; c < N_CPU; c++) begin : g_c
      assign owners[c] = status_o[c*N_LINES + l];
    end
    // R5
    one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(owners));
  end
endmodule

// File: tb/extirq_route_bench.sv
`timescale 1ns/1ps
module extirq_route_bench;
  localparam int NL = 64, NC = 4, NP = 4, CW = 2, PW = 2, NG = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NL-1:0]    irq = '0, en = '0;
  logic [NL*CW-1:0] core = '0;
  logic [NG*PW-1:0] pin_sel = '0;
  logic [NC*NL-1:0] clr = '0;
  logic [NC*NP-1:0] pin_o;
  logic [NC*NL-1:0] status_o;

  // model state
  logic [NL-1:0]    m_pend = '0, m_en = '0;
  logic [NL*CW-1:0] m_core = '0;
  logic [NC*NL-1:0] m_st = '0;
  logic [NG*PW-1:0] m_cap = '0;
  logic [NC*NP-1:0] m_pin = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  extirq_route #(.N_LINES(NL), .N_CPU(NC), .N_PIN(NP)) u_extirq_route (
    .clk_i(clk), .rst_ni, .irq_i(irq), .en_i(en), .core_sel_i(core),
    .pin_sel_i(pin_sel), .clr_i(clr), .pin_o, .status_o
  );

  task automatic model_update();
    logic [NC*NL-1:0] st;
    logic [NG*PW-1:0] eff;
    st = m_st;
    for (int l = 0; l < NL; l++) begin
      logic ev;
      ev = (irq[l] & ~m_pend[l]) | (en[l] & ~m_en[l]) |
           (core[l*CW +: CW] != m_core[l*CW +: CW]);
      for (int c = 0; c < NC; c++) begin
        if (core[l*CW +: CW] != CW'(c) || !irq[l] || !en[l] || clr[c*NL+l])
          st[c*NL+l] = 1'b0;
        else if (ev) st[c*NL+l] = 1'b1;
      end
    end
    for (int g = 0; g < NG; g++) begin
      logic busy;
      busy = 1'b0;
      for (int c = 0; c < NC; c++) busy |= |m_st[c*NL + g*32 +: 32];
      eff[g*PW +: PW] = busy ? m_cap[g*PW +: PW] : pin_sel[g*PW +: PW];
    end
    m_pin = '0;
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < NG; g++)
        if (|st[c*NL + g*32 +: 32]) m_pin[c*NP + int'(eff[g*PW +: PW])] = 1'b1;
    m_cap = eff; m_st = st; m_pend = irq; m_en = en; m_core = core;
  endtask

  task automatic compare(string tag);
    checks++;
    if (status_o !== m_st || pin_o !== m_pin) begin
      fails++;
      $display("FAIL %s: status=%h pin=%h expected status=%h pin=%h",
               tag, status_o, pin_o, m_st, m_pin);
    end
  endtask

  // inputs already set after a negedge; apply edge, then compare
  task automatic step(string tag);
    model_update();
    @(posedge clk); #1;
    compare(tag);
    @(negedge clk);
    clr = '0;
  endtask

  task automatic expect_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    compare("R1 reset");
    @(negedge clk);
    // R2: rise while disabled -> no status
    irq[5] = 1'b1; step("R2 disabled rise");
    expect_bit("R2 disabled rise", status_o[5], 1'b0);
    // R4: late enable on pending line; R9 no early change
    en[5] = 1'b1; #1;
    expect_bit("R9 before edge", status_o[5], 1'b0);
    step("R4 enable rise");
    expect_bit("R4 enable rise", status_o[0*NL+5], 1'b1);
    expect_bit("R6 pin cpu0 pin0", pin_o[0], 1'b1);
    // R5: move to cpu2
    core[5*CW +: CW] = 2'd2; step("R5 move");
    expect_bit("R5 old cpu", status_o[5], 1'b0);
    expect_bit("R5 new cpu", status_o[2*NL+5], 1'b1);
    // R6: group 1 line 40 -> cpu1, pin3
    pin_sel[1*PW +: PW] = 2'd3; core[40*CW +: CW] = 2'd1; en[40] = 1'b1;
    step("R6 setup");
    irq[40] = 1'b1; step("R2 enabled rise");
    expect_bit("R6 cpu1 pin3", pin_o[1*NP+3], 1'b1);
    // R7: map change while busy
    pin_sel[1*PW +: PW] = 2'd1; step("R7 busy remap");
    expect_bit("R7 held pin", pin_o[1*NP+3], 1'b1);
    expect_bit("R7 new pin idle", pin_o[1*NP+1], 1'b0);
    // R8: clear, no re-set while high
    clr[1*NL+40] = 1'b1; step("R8 clear");
    expect_bit("R8 cleared", status_o[1*NL+40], 1'b0);
    expect_bit("R8 pin low", pin_o[1*NP+3], 1'b0);
    step("R8 no re-set");
    expect_bit("R8 stays clear", status_o[1*NL+40], 1'b0);
    // R7: idle group now picks pin 1 on enable re-raise
    en[40] = 1'b0; step("R4 enable fall");
    en[40] = 1'b1; step("R7 recaptured");
    expect_bit("R7 new pin used", pin_o[1*NP+1], 1'b1);
    // R3: fall clears
    irq[5] = 1'b0; step("R3 fall");
    expect_bit("R3 fall", status_o[2*NL+5], 1'b0);
    // sweep: one kind of change per step
    for (int i = 0; i < 4000; i++) begin
      int kind;
      kind = int'($urandom_range(0, 5));
      case (kind)
        0, 1: begin
          irq ^= {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
          step("R2 R3 sweep lines");
        end
        2: begin
          en ^= {$urandom, $urandom} & {$urandom, $urandom};
          step("R4 sweep enables");
        end
        3: begin
          for (int k = 0; k < 3; k++)
            core[int'($urandom_range(0, NL-1))*CW +: CW] = CW'($urandom);
          step("R5 sweep reroute");
        end
        4: begin
          pin_sel = NG*PW'($urandom);
          step("R7 sweep remap");
        end
        default: begin
          clr = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                 $urandom, $urandom};
          step("R8 sweep clear");
        end
      endcase
    end
    rst_ni = 1'b0; #1;
    m_st = '0; m_pin = '0; m_pend = '0; m_en = '0; m_core = '0; m_cap = '0;
    compare("R1 re-reset");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule